// File: doc/BRIEF.md
# Constant-Coefficient Tap Multiplier Bank With One Shared Subterm

This block multiplies a single signed sample `x` by several fixed constants at once and places every product on its own output lane. It serves as the multiplier stage in a transposed or direct-form FIR filter. The constants are written in signed-digit form: each digit is +1, -1 or 0 and carries a power of two. Every coefficient has the same number of digits, `MAX_POW+1`, and the same input width. Digit position p therefore has weight 2^p in every lane. A shorter constant is padded with zero digits at its top end.

One digit pattern is given at elaboration, together with its base position. The pattern has at least two digits and at least two nonzero digits, and it must appear in at least two coefficients. Its sum of shifted copies is built once, as a wide shared term, at the highest position where the pattern occurs in any coefficient. Inside each coefficient the pattern is matched from the most significant digit downward, without overlap. Every match d positions below the base reuses the shared term shifted arithmetically right by d. Digits outside a match are added or subtracted as single shifted copies of `x`. A coefficient with no match is a flat signed sum, and an all-zero coefficient gives zero. All lanes draw on one set of left-shifted copies of `x`.

An illegal configuration stops elaboration. Illegal means a bad digit code, a pattern that is too short or too sparse, fewer than two coefficients using the pattern, or a base that is not the highest match. The lane results pass through one register stage with a clock enable and an asynchronous active-low reset.

Top module: `csd_tap_bank`

## Requirements
- R1: While `rst_n` is low, every lane of `prod` reads zero, whatever `en` and `x` do, and the clear takes effect without waiting for a clock edge.
- R2: On a rising `clk` edge with `rst_n` high and `en` high, lane k of `prod` takes the two's-complement product of `x` and coefficient k, truncated to `IN_W+MAX_POW` bits. The value is visible right after that one edge.
- R3: On a rising edge with `en` low, `prod` keeps its previous value whatever `x` does.
- R4: A coefficient whose digits are all zero yields a lane that is always zero. In the default set this is lane 3.
- R5: Each coefficient is `MAX_POW+1` two-bit digits, held in slice k of `COEF_DIG`, and digit p has weight 2^p. The codes are 01 = +1, 11 = -1 and 00 = 0; code 10 is refused at elaboration. The default lanes 0 to 3 hold the values 1584, 205, -1536 and 0.
- R6: The default pattern is +1, 0, -1 from high to low, with its lowest digit at base 9. Lane 0 is +0-00+0-0000 from power 11 down to power 0. It contains the pattern twice, the lower copy 5 positions below the base, and lane 0 equals 1584·x.
- R7: Matching runs from the top digit down without overlap, and unmatched digits count as single terms. Lane 1 is 000+0-0+0-0+; it has two matches plus a lone +1 at power 0, and lane 1 equals 205·x.
- R8: A coefficient without the pattern is summed flat. Lane 2 is -0+000000000 and equals -1536·x.
- R9: At the default sizes, the inputs -128 and 127 give exact products in every lane, with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the product register |
| rst_n | input | 1 | Asynchronous active-low reset, clears all lanes |
| en | input | 1 | Clock enable for the product register |
| x | input | IN_W (8) | Signed input sample |
| prod | output | NUM_COEF*(IN_W+MAX_POW) (4×19) | Packed signed products, lane k in slice k |

## Verification
A wrong match mask, a wrong base shift or a wrong digit sign makes one lane's value differ from x times its constant. The error appears on the first enabled edge with a nonzero `x`, one cycle after the sample is applied. A full sweep of every 8-bit input compares each lane against a behavioural product on every clock, so any wrong shared term shows up in several lanes during the first few samples. A faulty enable or reset path shows up as a changed value during a hold, or as a nonzero lane during reset.

// File: rtl/csd_tap_pkg.sv
`timescale 1ns/1ps
package csd_tap_pkg;

  // Two-bit signed digit codes; code 2'b10 is illegal.
  typedef enum logic [1:0] {
    DG_ZERO  = 2'b00,
    DG_PLUS  = 2'b01,
    DG_BAD   = 2'b10,
    DG_MINUS = 2'b11
  } dig_e;

  function automatic int dig_weight(logic [1:0] d);
    if (d == DG_PLUS)  return 1;
    if (d == DG_MINUS) return -1;
    return 0;
  endfunction

endpackage

// File: rtl/csd_tap_shifts.sv
`timescale 1ns/1ps
// One set of left-shifted, sign-extended input copies, shared by every lane.
module csd_tap_shifts #(
  parameter int IN_W    = 8,
  parameter int MAX_POW = 11,
  parameter int W_INT   = IN_W + MAX_POW + 2
) (
  input  logic signed [IN_W-1:0]           x,
  output logic        [MAX_POW:0][W_INT-1:0] sh
);

  logic [W_INT-1:0] x_ext;
  assign x_ext = {{(W_INT-IN_W){x[IN_W-1]}}, x};

  for (genvar p = 0; p <= MAX_POW; p++) begin : g_pow
    assign sh[p] = x_ext << p;
  end

endmodule

// File: rtl/csd_tap_shared.sv
`timescale 1ns/1ps
// Builds the common pattern once, anchored at its base power.
module csd_tap_shared
  import csd_tap_pkg::*;
#(
  parameter int                      MAX_POW  = 11,
  parameter int                      W_INT    = 21,
  parameter int                      PAT_LEN  = 3,
  parameter logic [PAT_LEN-1:0][1:0] PAT_DIG  = 6'b010011,
  parameter int                      PAT_BASE = 9
) (
  input  logic [MAX_POW:0][W_INT-1:0] sh,
  output logic [W_INT-1:0]            shared
);

  logic [W_INT-1:0] acc;

  always_comb begin
    acc = '0;
    for (int p = 0; p <= MAX_POW; p++) begin
      if (p >= PAT_BASE && p < PAT_BASE + PAT_LEN) begin
        if (PAT_DIG[p-PAT_BASE] == DG_PLUS)       acc = acc + sh[p];
        else if (PAT_DIG[p-PAT_BASE] == DG_MINUS) acc = acc - sh[p];
      end
    end
    shared = acc;
  end

endmodule

// File: rtl/csd_tap_coef.sv
`timescale 1ns/1ps
// One lane: unmatched digits as single terms plus shifted copies of the shared term.
module csd_tap_coef
  import csd_tap_pkg::*;
#(
  parameter int                      MAX_POW  = 11,
  parameter int                      W_INT    = 21,
  parameter int                      OUT_W    = 19,
  parameter logic [MAX_POW:0][1:0]   DIG      = '0,
  parameter logic [MAX_POW:0]        OCC      = '0,
  parameter logic [MAX_POW:0]        COVER    = '0,
  parameter int                      PAT_BASE = 9
) (
  input  logic [MAX_POW:0][W_INT-1:0] sh,
  input  logic [W_INT-1:0]            shared,
  output logic [OUT_W-1:0]            y
);

  logic [OUT_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int p = 0; p <= MAX_POW; p++) begin
      if (!COVER[p]) begin
        if (DIG[p] == DG_PLUS)       acc = acc + sh[p][OUT_W-1:0];
        else if (DIG[p] == DG_MINUS) acc = acc - sh[p][OUT_W-1:0];
      end
      if (OCC[p]) acc = acc + OUT_W'($signed(shared) >>> (PAT_BASE - p));
    end
    y = acc;
  end

endmodule

// File: rtl/csd_tap_bank.sv
`timescale 1ns/1ps
module csd_tap_bank
  import csd_tap_pkg::*;
#(
  parameter int NUM_COEF = 4,
  parameter int IN_W     = 8,
  parameter int MAX_POW  = 11,
  parameter logic [NUM_COEF-1:0][MAX_POW:0][1:0] COEF_DIG =
    96'h000000_C40000_013131_4C1300,
  parameter int                      PAT_LEN  = 3,
  parameter logic [PAT_LEN-1:0][1:0] PAT_DIG  = 6'b010011,
  parameter int                      PAT_BASE = 9
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      en,
  input  logic signed [IN_W-1:0]                    x,
  output logic [NUM_COEF-1:0][IN_W+MAX_POW-1:0]     prod
);

  localparam int OUT_W = IN_W + MAX_POW;
  localparam int W_INT = IN_W + MAX_POW + 2;  // shared term never wraps

  // ---- elaboration-time match planning ----
  function automatic bit match_at(int k, int lsb);
    for (int j = 0; j < PAT_LEN; j++)
      if (COEF_DIG[k][lsb+j] != PAT_DIG[j]) return 1'b0;
    return 1'b1;
  endfunction

  // Lowest-digit positions of matches, scanning from the top without overlap.
  function automatic logic [MAX_POW:0] occ_of(int k);
    logic [MAX_POW:0] m;
    int nxt;
    m   = '0;
    nxt = MAX_POW;
    for (int t = MAX_POW; t >= PAT_LEN - 1; t--) begin
      if (t <= nxt && match_at(k, t - PAT_LEN + 1)) begin
        m[t-PAT_LEN+1] = 1'b1;
        nxt = t - PAT_LEN;
      end
    end
    return m;
  endfunction

  function automatic logic [MAX_POW:0] cover_of(int k);
    logic [MAX_POW:0] m;
    logic [MAX_POW:0] o;
    m = '0;
    o = occ_of(k);
    for (int p = 0; p <= MAX_POW; p++)
      if (o[p])
        for (int j = 0; j < PAT_LEN; j++) m[p+j] = 1'b1;
    return m;
  endfunction

  function automatic bit config_ok();
    int nnz;
    int users;
    int top;
    logic [MAX_POW:0] o;
    if (PAT_LEN < 2 || PAT_BASE < 0 || PAT_BASE + PAT_LEN - 1 > MAX_POW) return 1'b0;
    nnz = 0;
    for (int j = 0; j < PAT_LEN; j++) begin
      if (PAT_DIG[j] == DG_BAD) return 1'b0;
      if (PAT_DIG[j] != DG_ZERO) nnz++;
    end
    if (nnz < 2) return 1'b0;
    users = 0;
    top   = -1;
    for (int k = 0; k < NUM_COEF; k++) begin
      for (int p = 0; p <= MAX_POW; p++)
        if (COEF_DIG[k][p] == DG_BAD) return 1'b0;
      o = occ_of(k);
      if (o != '0) users++;
      for (int p = 0; p <= MAX_POW; p++)
        if (o[p] && p > top) top = p;
    end
    return (users >= 2) && (top == PAT_BASE);
  endfunction

  localparam bit CFG_OK = config_ok();

  if (!CFG_OK) begin : g_cfg_bad
    $error("csd_tap_bank: illegal digit code or shared-pattern configuration");
  end

  // ---- datapath ----
  logic [MAX_POW:0][W_INT-1:0]        sh;
  logic [W_INT-1:0]                   shared;
  logic [NUM_COEF-1:0][OUT_W-1:0]     y_d;
  logic [NUM_COEF-1:0][OUT_W-1:0]     prod_d;
  logic [NUM_COEF-1:0][OUT_W-1:0]     prod_q;

  csd_tap_shifts #(
    .IN_W(IN_W), .MAX_POW(MAX_POW), .W_INT(W_INT)
  ) u_shifts (
    .x (x),
    .sh(sh)
  );

  csd_tap_shared #(
    .MAX_POW(MAX_POW), .W_INT(W_INT), .PAT_LEN(PAT_LEN),
    .PAT_DIG(PAT_DIG), .PAT_BASE(PAT_BASE)
  ) u_shared (
    .sh    (sh),
    .shared(shared)
  );

  for (genvar k = 0; k < NUM_COEF; k++) begin : g_lane
    localparam logic [MAX_POW:0] OCC_K   = occ_of(k);
    localparam logic [MAX_POW:0] COVER_K = cover_of(k);
    csd_tap_coef #(
      .MAX_POW(MAX_POW), .W_INT(W_INT), .OUT_W(OUT_W),
      .DIG(COEF_DIG[k]), .OCC(OCC_K), .COVER(COVER_K), .PAT_BASE(PAT_BASE)
    ) u_coef (
      .sh    (sh),
      .shared(shared),
      .y     (y_d[k])
    );
  end

  // ---- product register with clock enable ----
  always_comb begin
    prod_d = prod_q;
    if (en) prod_d = y_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= prod_d;
  end

  assign prod = prod_q;

endmodule

// File: rtl/csd_tap_bank_chk.sv
`timescale 1ns/1ps
module csd_tap_bank_chk
  import csd_tap_pkg::*;
#(
  parameter int NUM_COEF = 4,
  parameter int IN_W     = 8,
  parameter int MAX_POW  = 11,
  parameter logic [NUM_COEF-1:0][MAX_POW:0][1:0] COEF_DIG = '0
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  en,
  input logic signed [IN_W-1:0]                x,
  input logic [NUM_COEF-1:0][IN_W+MAX_POW-1:0] prod
);

  localparam int OUT_W = IN_W + MAX_POW;

  function automatic longint coef_val(int k);
    longint v;
    v = 0;
    for (int p = 0; p <= MAX_POW; p++)
      v = v + longint'(dig_weight(COEF_DIG[k][p])) * (longint'(1) <<< p);
    return v;
  endfunction

  // R1: lanes are zero when reset is released
  a_r1_reset_zero: assert property (@(posedge clk)
    $rose(rst_n) |-> prod == '0);

  // R3: no enable, no change
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en)) |-> $stable(prod));

  for (genvar k = 0; k < NUM_COEF; k++) begin : g_chk
    localparam longint CV = coef_val(k);

    // R2: each lane is the truncated product one edge after the sample
    a_r2_product: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(en)) |-> prod[k] == OUT_W'(longint'($past(x)) * CV));

    if (CV == 0) begin : g_zero
      // R4: zero coefficient lane never moves
      a_r4_zero_lane: assert property (@(posedge clk) disable iff (!rst_n)
        prod[k] == '0);
    end
  end

endmodule

bind csd_tap_bank csd_tap_bank_chk #(
  .NUM_COEF(NUM_COEF), .IN_W(IN_W), .MAX_POW(MAX_POW), .COEF_DIG(COEF_DIG)
) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .en   (en),
  .x    (x),
  .prod (prod)
);

// File: tb/csd_tap_bank_bench.sv
`timescale 1ns/1ps
module csd_tap_bank_bench;

  localparam int NC = 4;
  localparam int OW = 19;
  // Lane values from the digit strings of R5 (R6, R7, R8, R4 lanes)
  localparam longint CREF [NC] = '{1584, 205, -1536, 0};

  logic                 clk   = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 en    = 1'b0;
  logic signed [7:0]    x     = '0;
  logic [NC-1:0][OW-1:0] prod;
  logic [NC-1:0][OW-1:0] mdl;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string phase  = "R1";

  always #2.5 clk = ~clk;  // 200 MHz

  csd_tap_bank u_csd_tap_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .x    (x),
    .prod (prod)
  );

  // Behavioural reference: one register stage of plain products
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NC; k++) mdl[k] <= '0;
    end else if (en) begin
      for (int k = 0; k < NC; k++) mdl[k] <= OW'(longint'(x) * CREF[k]);
    end
  end

  function automatic string lane_tag(int k);
    case (k)
      0:       return "R6";
      1:       return "R7";
      2:       return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic compare();
    for (int k = 0; k < NC; k++) begin
      checks++;
      if (prod[k] !== mdl[k]) begin
        fails++;
        $display("FAIL %s %s R5 lane%0d x=%0d got=%h exp=%h",
                 phase, lane_tag(k), k, x, prod[k], mdl[k]);
      end
    end
  endtask

  task automatic step(input logic signed [7:0] xv, input logic ev);
    @(negedge clk);
    compare();
    x  = xv;
    en = ev;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    // R1: reset state, with enable raised to show reset wins
    phase = "R1";
    step(8'sd0, 1'b0);
    step(8'sd55, 1'b1);
    step(-8'sd3, 1'b1);
    step(8'sd0, 1'b0);
    rst_n = 1'b1;

    // R2: full sweep of the signed input range
    phase = "R2";
    for (int v = -128; v < 128; v++) step(8'(v), 1'b1);

    // R3: hold with changing input
    phase = "R3";
    step(8'sd19, 1'b1);
    step(8'sd101, 1'b0);
    step(-8'sd77, 1'b0);
    step(8'sd1, 1'b0);
    step(8'sd0, 1'b0);

    // R9: extremes
    phase = "R9";
    step(-8'sd128, 1'b1);
    step(8'sd127, 1'b1);
    step(-8'sd128, 1'b1);
    step(8'sd0, 1'b0);

    // R1: asynchronous clear in mid-run
    phase = "R1";
    step(8'sd33, 1'b1);
    step(8'sd90, 1'b1);
    rst_n = 1'b0;
    step(8'sd77, 1'b1);
    step(8'sd0, 1'b0);
    rst_n = 1'b1;
    phase = "R2";
    step(8'sd5, 1'b1);
    step(-8'sd1, 1'b1);
    step(8'sd0, 1'b0);
    @(negedge clk);
    compare();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements got=timeout exp=finish");
      summary();
      $finish;
    end
  end

endmodule